// File: doc/BRIEF.md
# Cache Set-Index Generator

This block turns a physical address into the set index of a level-one data cache. A small mode input picks how the index is formed. In linear mode the line-offset bits are dropped and the low bits that remain become the index. In polynomial hash mode each index bit is the XOR of a fixed group of address bits taken from bits 7 through 26. This spreads strided access patterns across the sets. The hash covers caches of 32 and 64 sets. With 64 sets the sixth index bit is taken straight from one address bit.

The block is purely combinational, so the index is valid in the same cycle as the address. It has no valid/ready handshake, because nothing is buffered and nothing can push back. The lookup pipeline that owns the address also owns the timing. The set count and line size are parameters. Any mode that cannot be honoured falls back to the linear index and raises an error flag. An undefined code, a reserved hash code, or the polynomial hash with a set count it does not support all behave this way. The cache keeps working in these cases, and the flag can be used to report the misconfiguration.

Top module: `set_index_gen`

## Requirements
- R1: With mode code 0 (linear), the index is (address >> log2(LINE_BYTES)) AND (SETS − 1), and the error flag is 0.
- R2: With mode code 2 (polynomial hash) and SETS of 32 or 64, index bit 0 is the XOR of address bits {7,12,15,17,18,21,22,23,24,25}. Bit 1 is the XOR of {8,13,16,18,19,22,23,24,25,26}. Bit 2 is the XOR of {9,12,14,15,18,19,20,21,22,26}.
- R3: In the same mode, index bit 3 is the XOR of address bits {10,13,15,16,19,20,21,22,23}, and bit 4 is the XOR of {11,14,16,17,20,21,22,23,24}.
- R4: With mode code 2 and SETS = 64, index bit 5 equals address bit 12.
- R5: With mode code 2 and SETS of 32 or 64, the error flag is 0, and address bits below 7 and above 26 have no effect on the index.
- R6: With mode code 4 (custom), the index equals the linear index of R1, and the error flag is 0.
- R7: Mode codes 1 (XOR permutation) and 3 (legacy hash) are reserved. They give the linear index of R1 with the error flag at 1.
- R8: Mode codes 5, 6 and 7 are undefined. They give the linear index of R1 with the error flag at 1.
- R9: With mode code 2 and a SETS value other than 32 or 64, the block gives the linear index of R1 with the error flag at 1.
- R10: The index and flag follow the address and mode within the same cycle, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Physical address of the access |
| mode_i | input | 3 | Index function select (0 linear, 1 and 3 reserved, 2 polynomial hash, 4 custom) |
| set_idx_o | output | log2(SETS) | Set index |
| idx_err_o | output | 1 | High when the selected function could not be applied and the linear index was given instead |

## Verification
The bound checker evaluates its properties whenever the inputs change. It confirms that the error flag follows the mode class (clear for linear and custom, set for reserved and undefined codes). It confirms that every flagged result equals the linear slice, and that the sixth hash bit tracks address bit 12. The XOR groups of each hash bit cannot be seen from single-cycle relations at the ports. They are shown only by the bench, which compares the outputs with separately written equations. It does so over walking-one and random addresses, on three set counts including an unsupported one. The bench also toggles address bits outside the hashed range to show they have no effect.

// File: rtl/set_index_pkg.sv
package set_index_pkg;

  typedef enum logic [2:0] {
    MODE_LINEAR  = 3'd0,
    MODE_XORPERM = 3'd1,
    MODE_POLY    = 3'd2,
    MODE_OLDHASH = 3'd3,
    MODE_USER    = 3'd4
  } idx_mode_e;

  // Span of address bits the polynomial hash draws on (bits 0..26).
  localparam int unsigned POLY_SPAN = 27;
  localparam int unsigned POLY_BITS = 5;

  // Taps of each hashed index bit, as a mask over address bits 0..26.
  function automatic logic [POLY_SPAN-1:0] poly_taps(input int unsigned bit_no);
    logic [POLY_SPAN-1:0] m;
    case (bit_no)
      0:       m = 27'h3E69080;
      1:       m = 27'h7CD2100;
      2:       m = 27'h47CD200;
      3:       m = 27'h0F9A400;
      4:       m = 27'h1F34800;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/idx_linear_slice.sv
module idx_linear_slice #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned SETS       = 64,
  localparam int unsigned IDX_W     = $clog2(SETS),
  localparam int unsigned SHIFT     = $clog2(LINE_BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);

  logic [ADDR_W-1:0] shifted;

  always_comb begin
    shifted = addr_i >> SHIFT;
    idx_o   = IDX_W'(shifted);
  end

endmodule

// File: rtl/idx_poly_hash.sv
module idx_poly_hash
  import set_index_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 64,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);

  logic [POLY_SPAN-1:0] span;
  assign span = POLY_SPAN'(addr_i);

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    if (b < POLY_BITS) begin : g_xor
      localparam logic [POLY_SPAN-1:0] TAPS = poly_taps(b);
      assign idx_o[b] = ^(span & TAPS);
    end else if (b == POLY_BITS) begin : g_plain
      assign idx_o[b] = span[12];
    end else begin : g_zero
      assign idx_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/idx_mode_decode.sv
module idx_mode_decode
  import set_index_pkg::*;
#(
  parameter bit HASH_OK = 1'b1
) (
  input  logic [2:0] mode_i,
  output logic       use_hash_o,
  output logic       err_o
);

  always_comb begin
    use_hash_o = 1'b0;
    err_o      = 1'b0;
    case (mode_i)
      MODE_LINEAR,
      MODE_USER:    err_o = 1'b0;
      MODE_POLY: begin
        use_hash_o = HASH_OK;
        err_o      = !HASH_OK;
      end
      default:      err_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/set_index_gen.sv
module set_index_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned SETS       = 64,
  localparam int unsigned IDX_W     = $clog2(SETS),
  localparam bit HASH_OK            = (SETS == 32) || (SETS == 64)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        mode_i,
  output logic [IDX_W-1:0]  set_idx_o,
  output logic              idx_err_o
);

  logic [IDX_W-1:0] lin_idx;
  logic [IDX_W-1:0] hash_idx;
  logic             use_hash;

  idx_linear_slice #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)
  ) u_lin (
    .addr_i(addr_i), .idx_o(lin_idx)
  );

  idx_poly_hash #(
    .ADDR_W(ADDR_W), .SETS(SETS)
  ) u_hash (
    .addr_i(addr_i), .idx_o(hash_idx)
  );

  idx_mode_decode #(
    .HASH_OK(HASH_OK)
  ) u_dec (
    .mode_i(mode_i), .use_hash_o(use_hash), .err_o(idx_err_o)
  );

  assign set_idx_o = use_hash ? hash_idx : lin_idx;

endmodule

// File: rtl/set_index_gen_chk.sv
module set_index_gen_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned SETS       = 64,
  localparam int unsigned IDX_W     = $clog2(SETS)
) (
  input logic [ADDR_W-1:0] addr_i,
  input logic [2:0]        mode_i,
  input logic [IDX_W-1:0]  set_idx_o,
  input logic              idx_err_o
);

  logic [IDX_W-1:0] slice_ref;
  logic             known;

  always_comb begin
    slice_ref = IDX_W'(addr_i / LINE_BYTES);
    known     = !$isunknown({addr_i, mode_i});
  end

  always_comb begin
    if (known) begin
      // R1, R6: linear and custom never flag
      p_no_err_lin_r1: assert (!((mode_i == 3'd0 || mode_i == 3'd4) && idx_err_o));
      // R7: reserved codes always flag
      p_err_reserved_r7: assert (!((mode_i == 3'd1 || mode_i == 3'd3) && !idx_err_o));
      // R8: undefined codes always flag
      p_err_undef_r8: assert (!(mode_i >= 3'd5 && !idx_err_o));
      // R9: any flagged result is the linear slice
      p_fallback_r9: assert (!idx_err_o || set_idx_o == slice_ref);
      // R6: custom gives the linear slice
      p_custom_r6: assert (mode_i != 3'd4 || set_idx_o == slice_ref);
      // R4: sixth hashed bit is address bit 12
      if (SETS == 64 && mode_i == 3'd2)
        p_bit5_r4: assert (set_idx_o[IDX_W-1] == addr_i[12]);
    end
  end

endmodule

bind set_index_gen set_index_gen_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS)
) u_chk (
  .addr_i(addr_i), .mode_i(mode_i), .set_idx_o(set_idx_o), .idx_err_o(idx_err_o)
);

// File: tb/test_set_index_gen.sv
module test_set_index_gen;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [31:0] addr;
  logic [2:0]  mode;
  logic [5:0]  idx64;
  logic [4:0]  idx32;
  logic [3:0]  idx16;
  logic        err64, err32, err16;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  set_index_gen #(.ADDR_W(32), .LINE_BYTES(128), .SETS(64)) i_set_index_gen (
    .addr_i(addr), .mode_i(mode), .set_idx_o(idx64), .idx_err_o(err64));
  set_index_gen #(.ADDR_W(32), .LINE_BYTES(64), .SETS(32)) i_set_index_gen_s32 (
    .addr_i(addr), .mode_i(mode), .set_idx_o(idx32), .idx_err_o(err32));
  set_index_gen #(.ADDR_W(32), .LINE_BYTES(32), .SETS(16)) i_set_index_gen_s16 (
    .addr_i(addr), .mode_i(mode), .set_idx_o(idx16), .idx_err_o(err16));

  function automatic logic [5:0] ref_hash(input logic [31:0] a);
    logic [5:0] h;
    h[0] = a[25]^a[24]^a[23]^a[22]^a[21]^a[18]^a[17]^a[15]^a[12]^a[7];
    h[1] = a[26]^a[25]^a[24]^a[23]^a[22]^a[19]^a[18]^a[16]^a[13]^a[8];
    h[2] = a[26]^a[22]^a[21]^a[20]^a[19]^a[18]^a[15]^a[14]^a[12]^a[9];
    h[3] = a[23]^a[22]^a[21]^a[20]^a[19]^a[16]^a[15]^a[13]^a[10];
    h[4] = a[24]^a[23]^a[22]^a[21]^a[20]^a[17]^a[16]^a[14]^a[11];
    h[5] = a[12];
    return h;
  endfunction

  function automatic logic [5:0] lin64(input logic [31:0] a); return 6'((a >> 7) & 32'd63); endfunction
  function automatic logic [4:0] lin32(input logic [31:0] a); return 5'((a >> 6) & 32'd31); endfunction
  function automatic logic [3:0] lin16(input logic [31:0] a); return 4'((a >> 5) & 32'd15); endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (addr %h mode %0d)", req, got, exp, addr, mode);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [2:0] m);
    @(posedge clk);
    addr = a;
    mode = m;
    #1;
  endtask

  task automatic t_zero;
    apply(32'h0, 3'd0);
    check("R1 zero idx", 8'(idx64), 8'h0);
    check("R1 zero err", 8'(err64), 8'h0);
  endtask

  task automatic t_linear;
    for (int i = 0; i < 40; i++) begin
      apply($urandom, 3'd0);
      check("R1 idx64", 8'(idx64), 8'(lin64(addr)));
      check("R1 idx32", 8'(idx32), 8'(lin32(addr)));
      check("R1 err", 8'(err64), 8'h0);
    end
  endtask

  task automatic t_hash_walk;
    for (int b = 0; b < 32; b++) begin
      apply(32'h1 << b, 3'd2);
      check("R2 R3 R4 walk64", 8'(idx64), 8'(ref_hash(addr)));
      check("R2 R3 walk32", 8'(idx32), 8'(ref_hash(addr) & 6'h1F));
    end
  endtask

  task automatic t_hash_random;
    for (int i = 0; i < 60; i++) begin
      apply($urandom, 3'd2);
      check("R2 R3 rnd64", 8'(idx64), 8'(ref_hash(addr)));
      check("R4 bit5", 8'(idx64[5]), 8'(addr[12]));
      check("R2 R3 rnd32", 8'(idx32), 8'(ref_hash(addr) & 6'h1F));
      check("R5 err64", 8'(err64), 8'h0);
      check("R5 err32", 8'(err32), 8'h0);
    end
  endtask

  task automatic t_hash_ignored_bits;
    logic [31:0] base;
    logic [5:0]  first;
    base = $urandom;
    apply(base, 3'd2);
    first = idx64;
    apply(base ^ 32'hF800_007F, 3'd2);
    check("R5 outside bits ignored", 8'(idx64), 8'(first));
  endtask

  task automatic t_custom;
    for (int i = 0; i < 20; i++) begin
      apply($urandom, 3'd4);
      check("R6 idx", 8'(idx64), 8'(lin64(addr)));
      check("R6 err", 8'(err64), 8'h0);
    end
  endtask

  task automatic t_reserved;
    for (int i = 0; i < 10; i++) begin
      apply($urandom, (i % 2 == 0) ? 3'd1 : 3'd3);
      check("R7 idx", 8'(idx64), 8'(lin64(addr)));
      check("R7 err", 8'(err64), 8'h1);
    end
  endtask

  task automatic t_undefined;
    for (int m = 5; m < 8; m++) begin
      apply($urandom, 3'(m));
      check("R8 idx", 8'(idx32), 8'(lin32(addr)));
      check("R8 err", 8'(err32), 8'h1);
    end
  endtask

  task automatic t_bad_sets;
    for (int i = 0; i < 10; i++) begin
      apply($urandom, 3'd2);
      check("R9 idx16", 8'(idx16), 8'(lin16(addr)));
      check("R9 err16", 8'(err16), 8'h1);
    end
  endtask

  task automatic t_same_cycle;
    @(posedge clk);
    addr = 32'h0000_1F80;
    mode = 3'd0;
    #1;
    check("R10 immediate", 8'(idx64), 8'h3F);
    mode = 3'd2;
    #1;
    check("R10 mode switch", 8'(idx64), 8'(ref_hash(32'h0000_1F80)));
  endtask

  initial begin
    addr = '0;
    mode = '0;
    t_zero();
    t_linear();
    t_hash_walk();
    t_hash_random();
    t_hash_ignored_bits();
    t_custom();
    t_reserved();
    t_undefined();
    t_bad_sets();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    #3;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule